// File: doc/BRIEF.md
# Adaptive F2F Bit Decoder

This block recovers data bits from a logic-level F2F (two-frequency, Aiken biphase) stream that has already been amplified and squared. Each bit cell begins with a transition. A one also carries a transition near the middle of the cell, and a zero does not. The block times the gaps between transitions with a counter on the system clock. It does not use a fixed rate. Instead it judges each bit against 70% of the mean length of the two bits before it, so a card that is swiped unevenly still decodes.

When a card starts, a run of clocking zeros is skipped. The select input sets whether the run is four bits or eight bits, and those bits also seed the length history. The active-low card flag then drops. From that point each decoded bit appears on a true output and a complement output, together with a one-cycle valid pulse. A bit is only released once the transition that opens the following bit has been seen. If the line stays quiet for the timeout period, the card flag rises again, the history is cleared and the block waits for a new card. After reset is released, a wake-up hold keeps the block deaf to the line.

Top module: `f2f_bit_decoder`

## Requirements
- R1: While `rst_n` is low and directly after it, `card_n` is 1, `bit_valid` is 0, `bit_out` is 0 and `bit_out_n` is 1. Taking `rst_n` low in the middle of a card drops that card at once.
- R2: For `WAKE_CYC` cycles after `rst_n` rises, every transition on `f2f_in` is ignored. In that window `card_n` stays 1 and no bit is emitted.
- R3: With `skip_long`=0, the first 4 bit cells after the first transition produce no output. `card_n` stays 1 through them and falls at the transition that opens the next cell.
- R4: With `skip_long`=1, the same rule as R3 holds with 8 skipped cells.
- R5: A cell is decoded as 1 when a transition arrives before 70% of the mean of the two previous cell lengths has passed since the cell began. The transition after that one closes the cell. Otherwise the cell is decoded as 0, and its next transition closes it. Cell lengths from 40 to 250 clocks, up to 2^`CNT_W`-1, decode correctly at a fixed rate.
- R6: The reference follows the stream. A per-cell rate drift of up to ±6% decodes correctly, and so do single short or long cells. A transition at 72% of the reference closes a 0 cell.
- R7: `bit_out_n` is always the complement of `bit_out`. Each decoded cell gives exactly one `bit_valid` pulse of one cycle, and `bit_valid` is only ever 1 while `card_n` is 0.
- R8: A cell's value is emitted only after the transition that opens the following cell. The last cell of a card is therefore released by a closing transition.
- R9: After `TIMEOUT_CYC` cycles with no transition, `card_n` returns to 1, and it does not do so earlier. The next card is skipped and reseeded afresh.
- R10: `bit_out` changes only in a cycle where `bit_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, enters the wake-up hold |
| f2f_in | input | 1 | Squared F2F line, asynchronous to `clk` |
| skip_long | input | 1 | Leading-skip length: 0 skips 4 cells, 1 skips 8 cells |
| bit_out | output | 1 | Last decoded bit |
| bit_out_n | output | 1 | Complement of `bit_out` |
| bit_valid | output | 1 | One-cycle strobe marking a new decoded bit |
| card_n | output | 1 | Low while a card is being decoded |

## Verification
A corrupted length history shows up as a wrong bit value. With a history that is too short, a real one is read as two zeros. With one that is too long, two zeros merge into a one. Either error is visible at the first `bit_valid` after it and it also changes the per-card bit count. A stuck or miscounted skip counter moves the fall of `card_n` by one or more cells and shifts the whole bit sequence. A wrong idle counter moves the rise of `card_n` relative to the last transition. The bench brackets that rise within about a hundred cycles of the timeout.

// File: rtl/f2f_pkg.sv
package f2f_pkg;

    typedef enum logic [1:0] {
        ST_WAKE = 2'd0,
        ST_HUNT = 2'd1,
        ST_SKIP = 2'd2,
        ST_DATA = 2'd3
    } dec_state_e;

endpackage

// File: rtl/f2f_edge_sync.sv
// Synchronises the raw line and flags each change of level with a one-cycle pulse.
module f2f_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_pulse
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign edge_pulse = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/f2f_interval_timer.sv
// Saturating cell-length counter plus a quiet-line watchdog.
module f2f_interval_timer #(
    parameter int CNT_W       = 20,
    parameter int TIMEOUT_CYC = 1562500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             activity,
    output logic [CNT_W-1:0] elapsed,
    output logic             quiet
);
    localparam int               IDLE_W   = $clog2(TIMEOUT_CYC + 1);
    localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  len_q, len_d;
    logic [IDLE_W-1:0] idle_q, idle_d;

    always_comb begin
        len_d  = len_q;
        idle_d = idle_q;
        if (restart)               len_d = CNT_W'(1);
        else if (len_q != CNT_MAX) len_d = len_q + CNT_W'(1);
        if (activity)              idle_d = '0;
        else if (idle_q != IDLE_LIM) idle_d = idle_q + IDLE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            idle_q <= '0;
        end else begin
            len_q  <= len_d;
            idle_q <= idle_d;
        end
    end

    assign elapsed = len_q;
    assign quiet   = (idle_q == IDLE_LIM);
endmodule

// File: rtl/f2f_period_cmp.sv
// Flags a transition as early when elapsed < 0.7 * (hist_a + hist_b) / 2,
// evaluated exactly as 20 * elapsed < 7 * (hist_a + hist_b).
module f2f_period_cmp #(
    parameter int CNT_W = 20
) (
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] hist_a,
    input  logic [CNT_W-1:0] hist_b,
    output logic             early
);
    localparam int CMP_W = CNT_W + 5;

    logic [CMP_W-1:0] lhs, rhs;

    always_comb begin
        lhs   = CMP_W'(elapsed) * CMP_W'(20);
        rhs   = (CMP_W'(hist_a) + CMP_W'(hist_b)) * CMP_W'(7);
        early = (lhs < rhs);
    end
endmodule

// File: rtl/f2f_bit_decoder.sv
module f2f_bit_decoder
    import f2f_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int TIMEOUT_CYC = 1562500,
    parameter int WAKE_CYC    = 1250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic f2f_in,
    input  logic skip_long,
    output logic bit_out,
    output logic bit_out_n,
    output logic bit_valid,
    output logic card_n
);
    localparam int                WAKE_W     = $clog2(WAKE_CYC + 1);
    localparam logic [WAKE_W-1:0] WAKE_LAST  = WAKE_W'(WAKE_CYC - 1);
    localparam int                SKIP_W     = 4;
    localparam logic [SKIP_W-1:0] SKIP_SHORT = SKIP_W'(4);
    localparam logic [SKIP_W-1:0] SKIP_LONG  = SKIP_W'(8);

    typedef struct packed {
        dec_state_e       st;
        logic [WAKE_W-1:0] wake_cnt;
        logic [SKIP_W-1:0] skip_cnt;
        logic [SKIP_W-1:0] skip_tgt;
        logic [CNT_W-1:0]  hist_a;
        logic [CNT_W-1:0]  hist_b;
        logic              half;
        logic              card_n;
        logic              bit_val;
        logic              valid;
    } dec_regs_t;

    dec_regs_t        r_q, r_d;
    logic             edge_seen;
    logic             restart;
    logic             quiet;
    logic             early;
    logic [CNT_W-1:0] elapsed;

    f2f_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (f2f_in),
        .edge_pulse (edge_seen)
    );

    f2f_interval_timer #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .activity (edge_seen),
        .elapsed  (elapsed),
        .quiet    (quiet)
    );

    f2f_period_cmp #(.CNT_W(CNT_W)) u_cmp (
        .elapsed (elapsed),
        .hist_a  (r_q.hist_a),
        .hist_b  (r_q.hist_b),
        .early   (early)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        restart   = 1'b0;
        unique case (r_q.st)
            ST_WAKE: begin
                if (r_q.wake_cnt == WAKE_LAST) r_d.st = ST_HUNT;
                else r_d.wake_cnt = r_q.wake_cnt + WAKE_W'(1);
            end
            ST_HUNT: begin
                if (edge_seen) begin
                    restart      = 1'b1;
                    r_d.st       = ST_SKIP;
                    r_d.skip_cnt = '0;
                    r_d.skip_tgt = skip_long ? SKIP_LONG : SKIP_SHORT;
                    r_d.hist_a   = '0;
                    r_d.hist_b   = '0;
                end
            end
            ST_SKIP: begin
                if (edge_seen) begin
                    restart    = 1'b1;
                    r_d.hist_b = r_q.hist_a;
                    r_d.hist_a = elapsed;
                    if (r_q.skip_cnt == r_q.skip_tgt - SKIP_W'(1)) begin
                        r_d.st     = ST_DATA;
                        r_d.card_n = 1'b0;
                        r_d.half   = 1'b0;
                    end else begin
                        r_d.skip_cnt = r_q.skip_cnt + SKIP_W'(1);
                    end
                end else if (quiet) begin
                    r_d.st     = ST_HUNT;
                    r_d.card_n = 1'b1;
                    r_d.hist_a = '0;
                    r_d.hist_b = '0;
                end
            end
            ST_DATA: begin
                if (edge_seen) begin
                    if (!r_q.half && early) begin
                        r_d.half = 1'b1;
                    end else begin
                        restart     = 1'b1;
                        r_d.bit_val = r_q.half;
                        r_d.valid   = 1'b1;
                        r_d.half    = 1'b0;
                        r_d.hist_b  = r_q.hist_a;
                        r_d.hist_a  = elapsed;
                    end
                end else if (quiet) begin
                    r_d.st     = ST_HUNT;
                    r_d.card_n = 1'b1;
                    r_d.half   = 1'b0;
                    r_d.hist_a = '0;
                    r_d.hist_b = '0;
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_WAKE;
            r_q.card_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_out   = r_q.bit_val;
    assign bit_out_n = ~r_q.bit_val;
    assign bit_valid = r_q.valid;
    assign card_n    = r_q.card_n;
endmodule

// File: rtl/f2f_bit_decoder_chk.sv
module f2f_bit_decoder_chk #(
    parameter int WAKE_CYC = 1250000
) (
    input logic clk,
    input logic rst_n,
    input logic bit_out,
    input logic bit_out_n,
    input logic bit_valid,
    input logic card_n
);
    localparam int                WAKE_W   = $clog2(WAKE_CYC + 1);
    localparam logic [WAKE_W-1:0] WAKE_LIM = WAKE_W'(WAKE_CYC);

    logic [WAKE_W-1:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst_q <= '0;
        else if (since_rst_q != WAKE_LIM) since_rst_q <= since_rst_q + WAKE_W'(1);
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (card_n && !bit_valid));

    a_r2_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < WAKE_LIM) |-> (card_n && !bit_valid));

    a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
        bit_out_n == !bit_out);

    a_r7_valid_in_card: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !card_n);

    a_r10_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_out));
endmodule

bind f2f_bit_decoder f2f_bit_decoder_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_out   (bit_out),
    .bit_out_n (bit_out_n),
    .bit_valid (bit_valid),
    .card_n    (card_n)
);

// File: tb/tb_f2f_bit_decoder.sv
module tb_f2f_bit_decoder;
    localparam int CNT_W   = 12;
    localparam int TIMEOUT = 1500;
    localparam int WAKE    = 400;
    localparam int NPAY    = 16;

    logic clk = 1'b0, rst_n = 1'b0, f2f = 1'b0, skip_long = 1'b0;
    logic bit_out, bit_out_n, bit_valid, card_n;

    always #4 clk = ~clk;

    f2f_bit_decoder #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT), .WAKE_CYC(WAKE)) dut (
        .clk(clk), .rst_n(rst_n), .f2f_in(f2f), .skip_long(skip_long),
        .bit_out(bit_out), .bit_out_n(bit_out_n), .bit_valid(bit_valid), .card_n(card_n)
    );

    int checks = 0, fails = 0, hold_err = 0, comp_err = 0, stray = 0;
    bit got_q[$];
    bit exp_q[$];
    logic last_bit = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                got_q.push_back(bit_out);
                last_bit = bit_out;
                if (card_n) stray++;
            end else if (bit_out !== last_bit) hold_err++;
            if (bit_out_n !== ~bit_out) comp_err++;
        end else last_bit = 1'b0;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input int p, input int mid);
        f2f = ~f2f;
        if (b) begin
            idle(mid);
            f2f = ~f2f;
            idle(p - mid);
        end else idle(p);
    endtask

    task automatic start_card(input bit long, input int p);
        int ldn;
        ldn = long ? 8 : 4;
        skip_long = long;
        got_q.delete(); exp_q.delete();
        hold_err = 0; comp_err = 0; stray = 0;
        for (int i = 0; i < ldn; i++) send_bit(1'b0, p, 0);
        check(card_n === 1'b1, long ? "R4" : "R3", "card_n during skip", card_n, 1);
        check(got_q.size() == 0, long ? "R4" : "R3", "bits during skip", got_q.size(), 0);
    endtask

    task automatic finish_card(input string req);
        idle(10);
        check(got_q.size() == exp_q.size() - 1, "R8", "bits before closing edge", got_q.size(), exp_q.size() - 1);
        f2f = ~f2f;
        idle(10);
        check(got_q.size() == exp_q.size(), "R7", "strobe count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < got_q.size()) check(got_q[i] == exp_q[i], req, $sformatf("bit %0d", i), got_q[i], exp_q[i]);
        end
        check(hold_err == 0, "R10", "bit_out changes without strobe", hold_err, 0);
        check(comp_err == 0 && stray == 0, "R7", "complement/strobe outside card", comp_err + stray, 0);
        idle(TIMEOUT - 120);
        check(card_n === 1'b0, "R9", "card_n before timeout", card_n, 0);
        idle(200);
        check(card_n === 1'b1, "R9", "card_n after timeout", card_n, 1);
    endtask

    task automatic random_card(input bit long, input int p0, input int drift);
        int p, step;
        bit b;
        p = p0;
        start_card(long, p);
        for (int k = 0; k < NPAY; k++) begin
            b = 1'($urandom % 2);
            exp_q.push_back(b);
            send_bit(b, p, p / 2);
            if (k == 0) check(card_n === 1'b0, long ? "R4" : "R3", "card_n after skip", card_n, 0);
            step = int'($urandom % (2 * drift + 1)) - drift;
            p = p + (p * step) / 100;
            if (p < 40) p = 40;
            if (p > 250) p = 250;
        end
        finish_card(drift == 0 ? "R5" : "R6");
    endtask

    task automatic dir_bit(input bit b, input int p, input int mid);
        exp_q.push_back(b);
        send_bit(b, p, mid);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_F2F0);
        idle(5);
        check(card_n === 1'b1 && bit_valid === 1'b0 && bit_out === 1'b0 && bit_out_n === 1'b1,
              "R1", "outputs in reset", {card_n, bit_valid, bit_out, bit_out_n}, 4'b1001);
        rst_n = 1'b1;
        idle(1);
        check(card_n === 1'b1 && bit_valid === 1'b0, "R1", "outputs after release", {card_n, bit_valid}, 2'b10);
        // R2: a burst inside the wake-up hold must be ignored
        idle(20);
        for (int i = 0; i < 6; i++) begin f2f = ~f2f; idle(30); end
        idle(WAKE + 400);
        check(card_n === 1'b1, "R2", "card_n after wake burst", card_n, 1);
        check(got_q.size() == 0, "R2", "bits from wake burst", got_q.size(), 0);

        // R6 directed: short/long cells around the 70% point
        start_card(1'b0, 100);
        dir_bit(1'b0, 100, 0);
        check(card_n === 1'b0, "R3", "card_n after skip", card_n, 0);
        dir_bit(1'b0, 80, 0);
        dir_bit(1'b1, 100, 55);
        dir_bit(1'b1, 100, 60);
        dir_bit(1'b0, 100, 0);
        dir_bit(1'b1, 70, 35);
        dir_bit(1'b0, 100, 0);
        dir_bit(1'b1, 100, 50);
        dir_bit(1'b0, 72, 0);
        dir_bit(1'b1, 100, 50);
        finish_card("R6");

        random_card(1'b0, 60, 0);
        random_card(1'b1, 200, 0);
        random_card(1'b1, 45, 5);
        random_card(1'b0, 240, 6);
        random_card(1'b1, 120, 6);
        random_card(1'b0, 90, 3);

        // R1: reset in the middle of a card
        start_card(1'b0, 80);
        send_bit(1'b1, 80, 40);
        send_bit(1'b0, 80, 0);
        rst_n = 1'b0;
        idle(3);
        check(card_n === 1'b1 && bit_valid === 1'b0 && bit_out === 1'b0 && bit_out_n === 1'b1,
              "R1", "outputs after mid-card reset", {card_n, bit_valid, bit_out, bit_out_n}, 4'b1001);
        idle(5);
        rst_n = 1'b1;
        idle(WAKE + 50);
        check(card_n === 1'b1, "R2", "card_n after wake", card_n, 1);
        random_card(1'b1, 80, 4);
        summary();
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule